// File: doc/BRIEF.md
# Issue Slot with Operand Wakeup

This block is one entry of an out-of-order issue queue. It holds a single dispatched micro-op: an opcode class, a destination register tag, and two physical source tags. Each source tag has a presence bit that shows whether its value is already in the register file. A queue is built from many copies of this slot. A separate select circuit, outside this block, reads the request lines and returns one grant per chosen slot.

Presence bits are set from two groups of wakeup buses. The fast group carries destination tags that single-cycle ALU micro-ops broadcast at the moment they issue. The slow group carries tags from the register-file write ports at write-back, which is the path for floating-point, load and variable-latency results. Every port compares its tag against both stored source tags at the same time. Once the slot holds a micro-op and both operands are present, it raises its request. A grant frees the slot. The slot accepts a new micro-op when it is empty, or in the same cycle that its current occupant is granted.

Top module: `issue_slot`

## Requirements
- R1: After reset, `busy` and `req` are 0.
- R2: When `disp_vld` is 1 and the slot is empty, or is being granted in that cycle, the slot loads the dispatched class, destination and source tags, which appear on the `out_*` ports from the next cycle with `busy` at 1. A dispatch that arrives while the slot is occupied and not granted is ignored, and the stored payload stays the same.
- R3: At dispatch, a source's presence bit is set when its use flag is 0 (the operand is unused) or when its ready flag is 1.
- R4: A valid fast wakeup port whose tag equals a stored source tag sets that source's presence bit on the next clock edge.
- R5: A valid slow wakeup port whose tag equals a stored source tag sets that source's presence bit on the next clock edge.
- R6: A wakeup that matches a dispatched source tag in the dispatch cycle sets that presence bit as the micro-op is loaded.
- R7: A wakeup port whose valid bit is 0 never matches, and a tag value of 0 never matches on any port.
- R8: `req` is 1 exactly when the slot is busy and both presence bits are set. Once set, a presence bit stays set until the slot is freed.
- R9: A `grant` while `req` is 1 frees the slot on the next edge. A `grant` while `req` is 0 has no effect.
- R10: `flush` empties the slot on the next edge and takes priority over both dispatch and grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the slot |
| disp_vld | input | 1 | A dispatched micro-op is offered |
| disp_cls | input | CLS_W | Opcode class of the offered micro-op |
| disp_dst | input | TAG_W | Destination tag |
| disp_s1 | input | TAG_W | Source 1 tag |
| disp_s1_use | input | 1 | Source 1 is used |
| disp_s1_rdy | input | 1 | Source 1 is ready at dispatch (from the busy table) |
| disp_s2 | input | TAG_W | Source 2 tag |
| disp_s2_use | input | 1 | Source 2 is used |
| disp_s2_rdy | input | 1 | Source 2 is ready at dispatch |
| fwk_vld | input | NF | Valid bits of the fast wakeup ports |
| fwk_tag | input | NF*TAG_W | Tags on the fast wakeup ports, port i in bits i*TAG_W and up |
| swk_vld | input | NS | Valid bits of the slow wakeup ports |
| swk_tag | input | NS*TAG_W | Tags on the slow wakeup ports, port i in bits i*TAG_W and up |
| grant | input | 1 | Issue grant from the select circuit |
| busy | output | 1 | The slot holds a micro-op |
| req | output | 1 | Issue request |
| out_cls | output | CLS_W | Stored opcode class |
| out_dst | output | TAG_W | Stored destination tag |
| out_s1 | output | TAG_W | Stored source 1 tag |
| out_s2 | output | TAG_W | Stored source 2 tag |

## Verification
A presence bit that is wrong inside the slot shows up on `req` in the cycle after the wakeup or dispatch that should have set it. A request that comes too early is as visible as one that never comes. A wrong valid bit shows up on `busy` within one cycle of a grant, a flush or an ignored dispatch. A payload that is corrupted or overwritten can be seen on the `out_*` ports at once. The bench therefore compares every output against its reference on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/issue_slot.sv
module issue_slot #(
  parameter int TAG_W = 6,
  parameter int CLS_W = 4,
  parameter int NF    = 2,
  parameter int NS    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                disp_vld,
  input  logic [CLS_W-1:0]    disp_cls,
  input  logic [TAG_W-1:0]    disp_dst,
  input  logic [TAG_W-1:0]    disp_s1,
  input  logic                disp_s1_use,
  input  logic                disp_s1_rdy,
  input  logic [TAG_W-1:0]    disp_s2,
  input  logic                disp_s2_use,
  input  logic                disp_s2_rdy,
  input  logic [NF-1:0]       fwk_vld,
  input  logic [NF*TAG_W-1:0] fwk_tag,
  input  logic [NS-1:0]       swk_vld,
  input  logic [NS*TAG_W-1:0] swk_tag,
  input  logic                grant,
  output logic                busy,
  output logic                req,
  output logic [CLS_W-1:0]    out_cls,
  output logic [TAG_W-1:0]    out_dst,
  output logic [TAG_W-1:0]    out_s1,
  output logic [TAG_W-1:0]    out_s2
);
  localparam int NW = NF + NS;

  logic [NW-1:0]       wk_vld;
  logic [NW*TAG_W-1:0] wk_tag;
  assign wk_vld = {swk_vld, fwk_vld};
  assign wk_tag = {swk_tag, fwk_tag};

  logic             vld_q, p1_q, p2_q;
  logic [CLS_W-1:0] cls_q;
  logic [TAG_W-1:0] dst_q, s1_q, s2_q;

  logic [NW-1:0] hit_s1, hit_s2, hit_d1, hit_d2;

  for (genvar i = 0; i < NW; i++) begin : g_cmp
    logic [TAG_W-1:0] t;
    logic             live;
    assign t         = wk_tag[i*TAG_W +: TAG_W];
    assign live      = wk_vld[i] && (t != '0);
    assign hit_s1[i] = live && (t == s1_q);
    assign hit_s2[i] = live && (t == s2_q);
    assign hit_d1[i] = live && (t == disp_s1);
    assign hit_d2[i] = live && (t == disp_s2);
  end

  logic issued, take;
  assign issued = grant && req;
  assign take   = disp_vld && !flush && (!vld_q || issued);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      p1_q  <= 1'b0;
      p2_q  <= 1'b0;
      cls_q <= '0;
      dst_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      cls_q <= disp_cls;
      dst_q <= disp_dst;
      s1_q  <= disp_s1;
      s2_q  <= disp_s2;
      p1_q  <= !disp_s1_use || disp_s1_rdy || (|hit_d1);
      p2_q  <= !disp_s2_use || disp_s2_rdy || (|hit_d2);
    end else if (flush || issued) begin
      vld_q <= 1'b0;
      p1_q  <= 1'b0;
      p2_q  <= 1'b0;
    end else if (vld_q) begin
      p1_q  <= p1_q || (|hit_s1);
      p2_q  <= p2_q || (|hit_s2);
    end
  end

  assign busy    = vld_q;
  assign req     = vld_q && p1_q && p2_q;
  assign out_cls = cls_q;
  assign out_dst = dst_q;
  assign out_s1  = s1_q;
  assign out_s2  = s2_q;

  // R8
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> busy);

  // R8
  req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant && !flush) |=> req);

  // R9
  grant_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && grant && !flush && !disp_vld) |=> !busy);

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);

  // R2
  payload_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush && !(grant && req)) |=> (busy && $stable(out_dst) && $stable(out_s1) && $stable(out_s2) && $stable(out_cls)));
endmodule

// File: tb/test_issue_slot.sv
module test_issue_slot;
  localparam int TAG_W = 6, CLS_W = 4, NF = 2, NS = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0, flush = 0, disp_vld = 0, grant = 0;
  logic [CLS_W-1:0] disp_cls = 0;
  logic [TAG_W-1:0] disp_dst = 0, disp_s1 = 0, disp_s2 = 0;
  logic disp_s1_use = 0, disp_s1_rdy = 0, disp_s2_use = 0, disp_s2_rdy = 0;
  logic [NF-1:0] fwk_vld = 0;
  logic [NF*TAG_W-1:0] fwk_tag = 0;
  logic [NS-1:0] swk_vld = 0;
  logic [NS*TAG_W-1:0] swk_tag = 0;
  logic busy, req;
  logic [CLS_W-1:0] out_cls;
  logic [TAG_W-1:0] out_dst, out_s1, out_s2;

  issue_slot #(.TAG_W(TAG_W), .CLS_W(CLS_W), .NF(NF), .NS(NS)) i_issue_slot (
    .clk, .rst_n, .flush, .disp_vld, .disp_cls, .disp_dst, .disp_s1,
    .disp_s1_use, .disp_s1_rdy, .disp_s2, .disp_s2_use, .disp_s2_rdy,
    .fwk_vld, .fwk_tag, .swk_vld, .swk_tag, .grant,
    .busy, .req, .out_cls, .out_dst, .out_s1, .out_s2);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_vld = 0, m_p1 = 0, m_p2 = 0, m_cls = 0, m_dst = 0, m_s1 = 0, m_s2 = 0;

  function automatic int hits(int tag);
    if (tag == 0) return 0;
    for (int i = 0; i < NF; i++)
      if (fwk_vld[i] && int'(fwk_tag[i*TAG_W +: TAG_W]) == tag) return 1;
    for (int i = 0; i < NS; i++)
      if (swk_vld[i] && int'(swk_tag[i*TAG_W +: TAG_W]) == tag) return 1;
    return 0;
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_req();
    return (m_vld && m_p1 && m_p2) ? 1 : 0;
  endfunction

  task automatic model_step();
    int r, take;
    r = m_req();
    if (!rst_n) begin
      m_vld = 0; m_p1 = 0; m_p2 = 0; m_cls = 0; m_dst = 0; m_s1 = 0; m_s2 = 0;
      return;
    end
    take = disp_vld && !flush && (!m_vld || (grant && r));
    if (take) begin
      m_vld = 1; m_cls = disp_cls; m_dst = disp_dst; m_s1 = disp_s1; m_s2 = disp_s2;
      m_p1 = (!disp_s1_use || disp_s1_rdy || hits(disp_s1)) ? 1 : 0;
      m_p2 = (!disp_s2_use || disp_s2_rdy || hits(disp_s2)) ? 1 : 0;
    end else if (flush || (grant && r)) begin
      m_vld = 0; m_p1 = 0; m_p2 = 0;
    end else if (m_vld) begin
      if (hits(m_s1)) m_p1 = 1;
      if (hits(m_s2)) m_p2 = 1;
    end
  endtask

  // inputs are already set (away from posedge); advance one clock and compare at negedge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(busy, m_vld, "R2 R9 R10 busy");
    chk(req, m_req(), "R8 req");
    if (m_vld) begin
      chk(out_cls, m_cls, "R2 cls");
      chk(out_dst, m_dst, "R2 dst");
      chk(out_s1, m_s1, "R2 s1");
      chk(out_s2, m_s2, "R2 s2");
    end
  endtask

  task automatic idle();
    flush = 0; disp_vld = 0; grant = 0; fwk_vld = 0; swk_vld = 0;
  endtask

  task automatic disp(int s1, int u1, int r1, int s2, int u2, int r2, int dst);
    disp_vld = 1; disp_cls = CLS_W'(dst + 1); disp_dst = TAG_W'(dst);
    disp_s1 = TAG_W'(s1); disp_s1_use = u1[0]; disp_s1_rdy = r1[0];
    disp_s2 = TAG_W'(s2); disp_s2_use = u2[0]; disp_s2_rdy = r2[0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    chk(busy, 0, "R1"); chk(req, 0, "R1");
    rst_n = 1;

    // R3: used source not ready, unused source present
    idle(); disp(5, 1, 0, 9, 0, 0, 11); tick();
    idle(); chk(req, 0, "R3");
    // R2: dispatch ignored while occupied
    disp(7, 0, 0, 8, 0, 0, 22); tick();
    idle(); chk(out_dst, 11, "R2"); chk(req, 0, "R2");
    // R4: fast wakeup
    fwk_vld = 2'b10; fwk_tag = {TAG_W'(5), TAG_W'(0)}; tick();
    idle(); chk(req, 1, "R4");
    // R9: grant frees
    grant = 1; tick(); idle(); chk(busy, 0, "R9");
    // R7: tag 0 never matches
    disp(0, 1, 0, 3, 0, 0, 4); fwk_vld = 2'b01; fwk_tag = '0; tick();
    idle(); chk(req, 0, "R7");
    swk_vld = 2'b11; swk_tag = '0; tick(); idle(); chk(req, 0, "R7");
    // R9: grant without req has no effect
    grant = 1; tick(); idle(); chk(busy, 1, "R9");
    // R10: flush clears, beats dispatch
    flush = 1; disp(1, 0, 0, 1, 0, 0, 9); tick(); idle(); chk(busy, 0, "R10");
    // R7: invalid port with matching tag
    disp(6, 1, 0, 2, 1, 1, 12); tick(); idle();
    fwk_vld = 0; fwk_tag = {TAG_W'(6), TAG_W'(6)}; tick(); idle(); chk(req, 0, "R7");
    // R5: slow wakeup
    swk_vld = 2'b10; swk_tag = {TAG_W'(6), TAG_W'(1)}; tick(); idle(); chk(req, 1, "R5");
    // R6: grant with same-cycle dispatch that matches a wakeup in that cycle
    grant = 1; disp(13, 1, 0, 14, 1, 0, 15);
    fwk_vld = 2'b01; fwk_tag = {TAG_W'(0), TAG_W'(13)};
    swk_vld = 2'b01; swk_tag = {TAG_W'(0), TAG_W'(14)};
    tick(); idle(); chk(busy, 1, "R2"); chk(out_dst, 15, "R2"); chk(req, 1, "R6");
    flush = 1; tick(); idle();

    for (int k = 0; k < 4000; k++) begin
      flush = ($urandom % 32) == 0;
      disp_vld = $urandom % 2;
      disp_cls = CLS_W'($urandom);
      disp_dst = TAG_W'($urandom);
      disp_s1 = TAG_W'($urandom % 4); disp_s2 = TAG_W'($urandom % 4);
      disp_s1_use = $urandom % 2; disp_s2_use = $urandom % 2;
      disp_s1_rdy = ($urandom % 4) == 0; disp_s2_rdy = ($urandom % 4) == 0;
      fwk_vld = NF'($urandom); swk_vld = NS'($urandom);
      fwk_tag = NF*TAG_W'({$urandom % 4, $urandom % 4} & 12'h0c3);
      for (int i = 0; i < NF; i++) fwk_tag[i*TAG_W +: TAG_W] = TAG_W'($urandom % 4);
      for (int i = 0; i < NS; i++) swk_tag[i*TAG_W +: TAG_W] = TAG_W'($urandom % 4);
      grant = $urandom % 2;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule